// File: doc/BRIEF.md
# NOR Flash Write-Buffer Program Sequencer

This block programs a run of consecutive words into a NOR flash device by way of the device's internal write buffer. A host pulses `start` with a first word address, a word count and the base address of the erase block that holds the run. The data words then arrive over a valid/ready stream. The sequencer splits the run into bursts that never cross a write-buffer boundary. For each burst it asks the device for a free buffer, loads the burst, commits it and polls the completion status.

The first burst is trimmed so that every later burst begins on a buffer boundary. A run stops early when the device reports a program fault or when a wait exceeds its time limit. Every run, cut short or not, finishes by clearing the device status, returning the device to array-read mode and pulsing `done`. The programming-power enable stays high for the whole run.

The flash port is a plain single-cycle bus. A write is one cycle with `fl_wr` high. A read is one cycle with `fl_rd` high, and the data comes back on `fl_rdata` in the following cycle.

Top module: `nor_burst_prog`

## Requirements
- R1: After reset, `busy`, `in_ready`, `prog_pwr`, `done`, `tmo`, `err_flags`, `fl_wr` and `fl_rd` are all low.
- R2: Each burst opens with a write of 0xE8 to the block base, followed by a read of the block base. This pair repeats until bit 7 of the returned word is 1, which means a buffer has been granted.
- R3: If no grant arrives within the timeout (CLK_HZ/1000*TMO_MS cycles, counted from the first request of the burst), the block writes 0x70 to the block base and reads it once. It then sets `tmo`, accepts no further data and ends the run.
- R4: After a grant, the block writes N-1 to the block base, N being the burst length. It then writes the N data words, in stream order, to consecutive addresses starting at the current run address.
- R5: Bursts follow the write-buffer size WB_WORDS, which is a power of two. The first burst holds WB_WORDS minus (start address mod WB_WORDS) words, limited to the run length. Each later burst holds the lesser of WB_WORDS and the words that remain. No burst crosses a WB_WORDS boundary.
- R6: After the data words, the block writes 0xD0 to the block base. It then reads the block base until bit 7 is 1. If that bit does not appear within the timeout, `tmo` is set and the run ends.
- R7: If the completion status has any of bits 1, 3, 4 or 5 set, `err_flags` is loaded as {bit5, bit4, bit3, bit1} and no further bursts are started.
- R8: `in_ready` is high only while a burst is being filled, that is, between the count write and the 0xD0 write.
- R9: Every run ends with a write of 0x50 and then a write of 0xFF to the block base. `done` pulses for one cycle in the cycle after the 0xFF write. `prog_pwr` and `busy` are high from the cycle after `start` is taken until that 0xFF write, and low once `done` is seen.
- R10: A run of length 0 issues only the 0x50 and 0xFF writes, then `done`.
- R11: `start` is ignored while `busy` is high.
- R12: `tmo` and `err_flags` hold their values after `done` and are cleared when the next run is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | AW | First word address of the run |
| run_len | input | LEN_W | Number of words in the run |
| block_base | input | AW | Base address of the erase block (command address) |
| in_data | input | DW | Data word stream |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted this cycle when valid |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_wr | output | 1 | Flash bus write strobe |
| fl_rd | output | 1 | Flash bus read strobe |
| fl_rdata | input | DW | Flash read data, one cycle after `fl_rd` |
| prog_pwr | output | 1 | Programming power enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| tmo | output | 1 | Last run ended on a timeout |
| err_flags | output | 4 | Fault bits from the last completion status |

## Verification
A bus operation appears in the same cycle that the sequencer state asserts it. Read data is due one cycle after `fl_rd`, so the bench's flash model registers its reply on that edge. A full grant attempt takes three cycles and a status poll takes two, so the number of retries before a timeout follows from the timeout constant. The bench computes that number and compares it with the logged operation list. `done` is due one cycle after the 0xFF write. The bench samples all outputs on the falling edge, waits for `done` under a cycle bound, and then checks the flags, the consumed word count and the whole logged bus sequence against a list it builds from the requirements.

// File: rtl/nor_burst_prog.sv
module nor_burst_prog #(
  parameter int AW       = 24,
  parameter int DW       = 16,
  parameter int LEN_W    = 16,
  parameter int WB_WORDS = 16,
  parameter int CLK_HZ   = 100_000_000,
  parameter int TMO_MS   = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_addr,
  input  logic [LEN_W-1:0] run_len,
  input  logic [AW-1:0]    block_base,
  input  logic [DW-1:0]    in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [AW-1:0]    fl_addr,
  output logic [DW-1:0]    fl_wdata,
  output logic             fl_wr,
  output logic             fl_rd,
  input  logic [DW-1:0]    fl_rdata,
  output logic             prog_pwr,
  output logic             busy,
  output logic             done,
  output logic             tmo,
  output logic [3:0]       err_flags
);
  localparam int LW      = $clog2(WB_WORDS);
  localparam int BW      = LW + 1;
  localparam int TMO_CYC = CLK_HZ / 1000 * TMO_MS;
  localparam int TW      = $clog2(TMO_CYC + 1);

  localparam logic [7:0] C_BUFREQ = 8'hE8;
  localparam logic [7:0] C_STATRD = 8'h70;
  localparam logic [7:0] C_COMMIT = 8'hD0;
  localparam logic [7:0] C_CLRST  = 8'h50;
  localparam logic [7:0] C_ARRAY  = 8'hFF;
  localparam logic [7:0] FAULT_M  = 8'h3A;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_RDX, S_WAITX, S_STQ, S_STRD, S_STCAP,
    S_CNT, S_FILL, S_CONF, S_PRD, S_PCHK, S_CLR, S_RMODE
  } st_t;

  st_t              st;
  logic [AW-1:0]    cur, blk;
  logic [LEN_W-1:0] rem;
  logic [BW-1:0]    bcnt;
  logic [TW-1:0]    tmr;

  wire [BW-1:0] room    = BW'(WB_WORDS) - {1'b0, cur[LW-1:0]};
  wire [BW-1:0] nb      = (rem < LEN_W'(room)) ? BW'(rem) : room;
  wire          expired = tmr >= TW'(TMO_CYC - 1);
  wire          take    = in_valid && in_ready;
  wire [7:0]    stat    = fl_rdata[7:0];

  assign busy     = st != S_IDLE;
  assign prog_pwr = busy;
  assign in_ready = st == S_FILL;

  always_comb begin
    fl_wr    = 1'b0;
    fl_rd    = 1'b0;
    fl_addr  = blk;
    fl_wdata = '0;
    case (st)
      S_REQ:   begin fl_wr = 1'b1; fl_wdata = DW'(C_BUFREQ); end
      S_STQ:   begin fl_wr = 1'b1; fl_wdata = DW'(C_STATRD); end
      S_CNT:   begin fl_wr = 1'b1; fl_wdata = DW'(nb - BW'(1)); end
      S_FILL:  begin fl_wr = in_valid; fl_addr = cur; fl_wdata = in_data; end
      S_CONF:  begin fl_wr = 1'b1; fl_wdata = DW'(C_COMMIT); end
      S_CLR:   begin fl_wr = 1'b1; fl_wdata = DW'(C_CLRST); end
      S_RMODE: begin fl_wr = 1'b1; fl_wdata = DW'(C_ARRAY); end
      S_RDX, S_STRD, S_PRD: fl_rd = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur       <= '0;
      blk       <= '0;
      rem       <= '0;
      bcnt      <= '0;
      tmr       <= '0;
      tmo       <= 1'b0;
      err_flags <= '0;
      done      <= 1'b0;
    end else begin
      done <= st == S_RMODE;
      if (tmr != TW'(TMO_CYC)) tmr <= tmr + TW'(1);
      case (st)
        S_IDLE: if (start) begin
          cur       <= start_addr;
          blk       <= block_base;
          rem       <= run_len;
          tmo       <= 1'b0;
          err_flags <= '0;
          tmr       <= '0;
          st        <= (run_len == '0) ? S_CLR : S_REQ;
        end
        S_REQ:   st <= S_RDX;
        S_RDX:   st <= S_WAITX;
        S_WAITX: st <= stat[7] ? S_CNT : (expired ? S_STQ : S_REQ);
        S_STQ:   st <= S_STRD;
        S_STRD:  st <= S_STCAP;
        S_STCAP: begin tmo <= 1'b1; st <= S_CLR; end
        S_CNT:   begin bcnt <= nb; st <= S_FILL; end
        S_FILL: if (take) begin
          cur  <= cur + AW'(1);
          rem  <= rem - LEN_W'(1);
          bcnt <= bcnt - BW'(1);
          if (bcnt == BW'(1)) st <= S_CONF;
        end
        S_CONF: begin tmr <= '0; st <= S_PRD; end
        S_PRD:  st <= S_PCHK;
        S_PCHK: begin
          if (stat[7]) begin
            if ((stat & FAULT_M) != '0) begin
              err_flags <= {stat[5], stat[4], stat[3], stat[1]};
              st <= S_CLR;
            end else if (rem == '0) begin
              st <= S_CLR;
            end else begin
              tmr <= '0;
              st  <= S_REQ;
            end
          end else if (expired) begin
            tmo <= 1'b1;
            st  <= S_CLR;
          end else begin
            st <= S_PRD;
          end
        end
        S_CLR:   st <= S_RMODE;
        S_RMODE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_count_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITX && stat[7]) |=> (fl_wr && fl_addr == blk && fl_wdata < DW'(WB_WORDS)));

  p_no_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr && in_ready && (&fl_addr[LW-1:0])) |=> !in_ready);

  p_fill_after_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(fl_wr && !fl_rd));

  p_fault_then_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|err_flags) |-> (fl_wr && fl_wdata == DW'(C_CLRST)));

  p_tmo_then_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> (fl_wr && fl_wdata == DW'(C_CLRST)));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!prog_pwr && !in_ready && !fl_wr));

  p_target_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(blk));
endmodule

// File: tb/test_nor_burst_prog.sv
module test_nor_burst_prog;
  localparam int PER = 10;
  localparam int AW = 16, DW = 16, LEN_W = 16, WB = 8;
  localparam int TMO = 40;
  localparam logic [AW-1:0] BLK = 16'h1000;

  logic clk = 0, rst_n = 0, start = 0, in_valid;
  logic [AW-1:0] start_addr = '0, block_base = BLK;
  logic [LEN_W-1:0] run_len = '0;
  logic [DW-1:0] in_data, fl_wdata, fl_rdata = '0;
  logic [AW-1:0] fl_addr;
  logic in_ready, fl_wr, fl_rd, prog_pwr, busy, done, tmo;
  logic [3:0] err_flags;

  always #(PER/2) clk = ~clk;

  nor_burst_prog #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .WB_WORDS(WB),
                   .CLK_HZ(20000), .TMO_MS(2)) i_nor_burst_prog (
    .clk, .rst_n, .start, .start_addr, .run_len, .block_base, .in_data,
    .in_valid, .in_ready, .fl_addr, .fl_wdata, .fl_wr, .fl_rd, .fl_rdata,
    .prog_pwr, .busy, .done, .tmo, .err_flags);

  int total = 0, bad = 0;

  // data source
  logic [DW-1:0] src_mem [0:63];
  int src_idx = 0, src_len = 0, cyc = 0;
  logic src_load = 0, gap = 0;
  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_load) src_idx <= 0;
    else if (in_valid && in_ready) src_idx <= src_idx + 1;
  end
  assign in_valid = (src_idx < src_len) && !(gap && cyc[1:0] == 2'd0);
  assign in_data  = src_mem[src_idx < 64 ? src_idx : 0];

  // flash model and bus log
  logic [AW-1:0] lg_a [0:511];
  logic [DW-1:0] lg_d [0:511];
  logic          lg_k [0:511];
  int nlog = 0, deny_left = 0, busy_left = 0, cfg_deny = 0, cfg_sbusy = 0;
  int ready_viol = 0, pwr_viol = 0;
  logic [7:0] cfg_err = 0;
  int mode = 0;       // 0 read, 1 buffer query, 2 status
  logic fill_win = 0, model_clr = 0;

  always @(posedge clk) begin
    if (model_clr) begin
      nlog = 0; deny_left = cfg_deny; busy_left = cfg_sbusy; mode = 0; fill_win = 0;
    end else begin
      if (in_ready && !fill_win) ready_viol++;
      if (busy && !prog_pwr) pwr_viol++;
      if (fl_wr || fl_rd) begin
        if (nlog < 512) begin
          lg_a[nlog] = fl_addr; lg_d[nlog] = fl_wdata; lg_k[nlog] = fl_rd; nlog++;
        end
      end
      if (fl_rd) begin
        if (mode == 1) begin
          if (deny_left > 0) begin fl_rdata <= 16'h0000; deny_left--; end
          else fl_rdata <= 16'h0080;
        end else if (mode == 2) begin
          if (busy_left > 0) begin fl_rdata <= 16'h0000; busy_left--; end
          else fl_rdata <= {8'h00, 8'h80 | cfg_err};
        end else fl_rdata <= 16'h00AA;
      end
      if (fl_wr && fl_addr == BLK) begin
        if (fl_wdata == 16'hE8) mode = 1;
        else if (fl_wdata == 16'hD0) begin
          mode = 2; fill_win = 0; deny_left = cfg_deny; busy_left = cfg_sbusy;
        end else if (fl_wdata == 16'h70) mode = 2;
        else if (fl_wdata == 16'h50 || fl_wdata == 16'hFF) mode = 0;
        else if (mode == 1) fill_win = 1;
      end
    end
  end

  // expected sequence
  logic [AW-1:0] ex_a [0:511];
  logic [DW-1:0] ex_d [0:511];
  logic          ex_k [0:511];
  int nex = 0;
  task automatic ew(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ex_a[nex] = a; ex_d[nex] = d; ex_k[nex] = 0; nex++;
  endtask
  task automatic er(input logic [AW-1:0] a);
    ex_a[nex] = a; ex_d[nex] = 'x; ex_k[nex] = 1; nex++;
  endtask

  task automatic chk(input string req, input logic ok, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_seq(input string req);
    int mism = -1;
    for (int i = 0; i < nex && i < nlog; i++)
      if (mism < 0 && (lg_k[i] != ex_k[i] || lg_a[i] != ex_a[i] ||
          (!ex_k[i] && lg_d[i] != ex_d[i]))) mism = i;
    chk(req, nlog == nex, "bus op count", nlog, nex);
    if (mism >= 0)
      chk(req, 1'b0, $sformatf("bus op %0d addr/data", mism),
          {lg_a[mism], lg_d[mism]}, {ex_a[mism], ex_d[mism]});
    else chk(req, 1'b1, "bus op order", 0, 0);
  endtask

  task automatic build_normal(input int sa, input int len, input int d,
                              input int s, input logic [7:0] e);
    int cur = sa, left = len, k = 0;
    nex = 0;
    while (left > 0) begin
      int n = WB - (cur % WB);
      if (left < n) n = left;
      for (int j = 0; j <= d; j++) begin ew(BLK, 16'hE8); er(BLK); end
      ew(BLK, DW'(n - 1));
      for (int j = 0; j < n; j++) begin ew(AW'(cur), src_mem[k]); cur++; k++; end
      left -= n;
      ew(BLK, 16'hD0);
      for (int j = 0; j <= s; j++) er(BLK);
      if (e & 8'h3A) left = 0;
    end
    ew(BLK, 16'h50); ew(BLK, 16'hFF);
  endtask

  task automatic setup(input int len, input int d, input int s,
                       input logic [7:0] e, input logic g);
    @(negedge clk);
    for (int i = 0; i < 64; i++) src_mem[i] = DW'(16'h1100 + i * 3);
    cfg_deny = d; cfg_sbusy = s; cfg_err = e; gap = g;
    src_len = len; src_load = 1; model_clr = 1;
    @(negedge clk);
    src_load = 0; model_clr = 0; ready_viol = 0; pwr_viol = 0;
  endtask

  task automatic launch(input int sa, input int len, input logic poke);
    start_addr = AW'(sa); run_len = LEN_W'(len); start = 1;
    @(negedge clk);
    start = 0;
    chk("R9", busy && prog_pwr, "busy/pwr after start", {busy, prog_pwr}, 2'b11);
    chk("R12", !tmo && err_flags == 0, "flags cleared at start", {tmo, err_flags}, 0);
    if (poke) begin
      repeat (4) @(negedge clk);
      start_addr = 16'h1035; run_len = 2; start = 1;   // R11: must be ignored
      @(negedge clk);
      start = 0;
    end
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(req, done, "done pulse", done, 1);
    chk("R9", !busy && !prog_pwr, "idle at done", {busy, prog_pwr}, 0);
    chk("R9", pwr_viol == 0, "power held during run", pwr_viol, 0);
    chk("R8", ready_viol == 0, "ready outside fill", ready_viol, 0);
    @(negedge clk);
    chk("R9", !done, "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk("R1", !busy && !in_ready && !prog_pwr && !done, "reset outputs",
        {busy, in_ready, prog_pwr, done}, 0);
    chk("R1", !tmo && err_flags == 0 && !fl_wr && !fl_rd, "reset flags/bus",
        {tmo, err_flags, fl_wr, fl_rd}, 0);
  endtask

  task automatic t_normal(input string req, input int sa, input int len, input int d,
                          input int s, input logic g, input logic poke);
    setup(len, d, s, 8'h00, g);
    build_normal(sa, len, d, s, 8'h00);
    launch(sa, len, poke);
    wait_done(req);
    cmp_seq(req);
    chk(req, src_idx == len, "words taken", src_idx, len);
    chk("R12", !tmo && err_flags == 0, "flags after clean run", {tmo, err_flags}, 0);
  endtask

  task automatic t_fault;
    setup(12, 0, 1, 8'h12, 0);
    build_normal(16'h1015, 12, 0, 1, 8'h12);
    launch(16'h1015, 12, 0);
    wait_done("R7");
    cmp_seq("R7");
    chk("R7", err_flags == 4'b0101, "fault flags", err_flags, 4'b0101);
    chk("R7", src_idx == 3, "stopped after first burst", src_idx, 3);
    chk("R12", err_flags == 4'b0101, "flags held after done", err_flags, 4'b0101);
  endtask

  task automatic t_grant_tmo;
    int k = 0;
    setup(4, 100000, 0, 8'h00, 0);
    while (3 * k + 2 < TMO - 1) k++;
    nex = 0;
    for (int j = 0; j <= k; j++) begin ew(BLK, 16'hE8); er(BLK); end
    ew(BLK, 16'h70); er(BLK); ew(BLK, 16'h50); ew(BLK, 16'hFF);
    launch(16'h1010, 4, 0);
    wait_done("R3");
    cmp_seq("R3");
    chk("R3", tmo && err_flags == 0, "grant timeout flag", {tmo, err_flags}, 5'b10000);
    chk("R3", src_idx == 0, "no data taken", src_idx, 0);
  endtask

  task automatic t_stat_tmo;
    int p = 0;
    setup(4, 0, 100000, 8'h00, 0);
    while (2 * p + 1 < TMO - 1) p++;
    nex = 0;
    ew(BLK, 16'hE8); er(BLK); ew(BLK, 16'd3);
    for (int j = 0; j < 4; j++) ew(AW'(16'h1020 + j), src_mem[j]);
    ew(BLK, 16'hD0);
    for (int j = 0; j <= p; j++) er(BLK);
    ew(BLK, 16'h50); ew(BLK, 16'hFF);
    launch(16'h1020, 4, 0);
    wait_done("R6");
    cmp_seq("R6");
    chk("R6", tmo && err_flags == 0, "status timeout flag", {tmo, err_flags}, 5'b10000);
  endtask

  task automatic t_zero;
    setup(0, 0, 0, 8'h00, 0);
    nex = 0; ew(BLK, 16'h50); ew(BLK, 16'hFF);
    launch(16'h1040, 0, 0);
    wait_done("R10");
    cmp_seq("R10");
  endtask

  initial begin
    #(PER * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_normal("R4", 16'h1010, 16, 0, 0, 0, 0);   // two aligned full bursts (R2 R5 R6)
    t_normal("R5", 16'h1013, 13, 2, 3, 1, 0);   // first burst 5 then 8, retries, gaps
    t_normal("R2", 16'h1021, 3, 4, 0, 0, 0);    // short run inside one buffer
    t_fault();
    t_grant_tmo();
    t_normal("R12", 16'h1008, 9, 0, 2, 0, 0);   // clean run after a timeout
    t_stat_tmo();
    t_zero();
    t_normal("R11", 16'h1016, 10, 1, 1, 0, 1);  // start pulsed mid-run
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule